// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This block sequences one frame attempt of a half-duplex Ethernet transmitter on a 4-bit media interface. It advances once per nibble clock. It first makes the transmitter defer to traffic on the medium. It then grants the start of a frame. It tracks where the frame stands through strobes from the nibble datapath, and it decides what a collision means for the frame.

Deferral has two phases. The first phase needs the carrier to stay low without a break. The second phase runs to its end whatever the carrier does. A collision always produces a jam of 32 bits. Before the jam, the block finishes the preamble if it is still in progress. A collision inside the collision window, which is counted from the SFD, asks an external backoff unit to retry and raises the retry count. A collision after the window is a late collision: the attempt is aborted, the retry count is cleared and a sticky status flag is set. The flag drives an interrupt that software can mask.

Top module: `hd_tx_coll_ctrl`

## Requirements
- R1: `tx_start_o` is a one-cycle pulse. It is high only when the block is idle, deferral is complete, `tx_req_i` is high and `crs_i` is low. If carrier is seen in a cycle where deferral was complete, there is no start in that cycle and deferral begins again.
- R2: After reset, and after every frame attempt ends, the earliest `tx_start_o` comes in the cycle after 24 clock edges of deferral: 15 edges with carrier low, then 9 more.
- R3: Carrier seen during the first 15 deferral cycles restarts the count from zero. Carrier seen during the following 9 cycles has no effect on when the start comes.
- R4: A collision counts as normal if it comes in the cycle where `sfd_sent_i` is high, in any earlier cycle of the attempt, or in any of the 128 cycles after that cycle. A collision from the 129th cycle after `sfd_sent_i` onward counts as late.
- R5: For a normal collision, `jam_o` is high for 8 consecutive cycles, starting in the cycle after the collision is acted on. `retry_o` pulses in the last jam cycle, and `retry_cnt_o` then goes up by one, holding at its maximum.
- R6: A collision seen before the preamble is complete is held. Jam starts in the cycle after `pre_done_i`.
- R7: A collision during the FCS that comes before its last three cycles still produces the full 8-cycle jam.
- R8: A collision in the last three FCS cycles is ignored. These are FCS cycles 5, 6 and 7, counting the cycles with `fcs_active_i` high from 0 to 7. The frame ends normally, and the block is idle again in the cycle after `last_nib_i`.
- R9: For a late collision, the block still jams for 8 cycles. It then pulses `abort_o` in the last jam cycle and does not pulse `retry_o`. The retry count clears and `late_col_o` sets at the next edge.
- R10: `late_col_o` resets to 0 and holds its value until `lc_clr_i` clears it at an edge. If a set and a clear fall on the same edge, the set wins.
- R11: `irq_o` is high exactly when `late_col_o` and `lc_irq_en_i` are both high.
- R12: A frame that completes without a collision clears `retry_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_i | input | 1 | A frame is waiting to be sent |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision, already synchronized |
| pre_done_i | input | 1 | Strobe: preamble complete |
| sfd_sent_i | input | 1 | Strobe: last SFD nibble sent |
| fcs_active_i | input | 1 | The current nibble is part of the FCS |
| last_nib_i | input | 1 | Strobe: last FCS nibble sent |
| lc_irq_en_i | input | 1 | Late-collision interrupt enable |
| lc_clr_i | input | 1 | Write-one-to-clear of the late flag |
| tx_start_o | output | 1 | Grant to start a frame |
| jam_o | output | 1 | Datapath sends jam nibbles |
| retry_o | output | 1 | Retry request to the backoff unit |
| abort_o | output | 1 | Attempt aborted after a late collision |
| late_col_o | output | 1 | Sticky late-collision flag |
| irq_o | output | 1 | Late-collision interrupt |
| retry_cnt_o | output | 4 | Retries of the current frame |

## Verification
The late flag can be set by the abort at the end of a late-collision jam and cleared by software on the same edge. The bench provokes this by raising `lc_clr_i` in exactly the cycle where `abort_o` pulses, while the flag is still set from an earlier late collision. It then requires the flag to still be 1 one cycle later, and to drop only after a clear that comes on its own. The second same-cycle case is the start grant against carrier: the bench raises carrier in the very cycle where deferral completes. It then expects no start in that cycle and a start exactly 25 cycles later.

// File: rtl/hd_tx_pkg.sv
package hd_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_JAM} tx_state_e;
endpackage

// File: rtl/hd_tx_defer.sv
module hd_tx_defer #(
  parameter int IFG1 = 15,
  parameter int IFG2 = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic crs_i,
  output logic ready_o
);
  localparam int TOTAL = IFG1 + IFG2;
  localparam int W = $clog2(TOTAL + 1);
  localparam logic [W-1:0] P1_C  = W'(IFG1);
  localparam logic [W-1:0] TOT_C = W'(TOTAL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q < P1_C)     cnt_q <= crs_i ? '0 : cnt_q + 1'b1;
    else if (cnt_q < TOT_C)    cnt_q <= cnt_q + 1'b1;  // phase 2 ignores carrier
    else if (crs_i)            cnt_q <= '0;
  end

  assign ready_o = (cnt_q == TOT_C);

  // R3
  phase1_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && crs_i && cnt_q < P1_C) |=> (cnt_q == '0));
  // R3
  phase2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q >= P1_C && cnt_q < TOT_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hd_tx_window.sv
module hd_tx_window #(
  parameter int WIN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sfd_i,
  output logic late_o
);
  localparam int W = $clog2(WIN + 1);
  localparam logic [W-1:0] WIN_C = W'(WIN);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (sfd_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && cnt_q != WIN_C) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign late_o = run_q && (cnt_q == WIN_C);

  // R4
  late_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_o && !start_i && !sfd_i) |=> late_o);
endmodule

// File: rtl/hd_tx_jam.sv
module hd_tx_jam #(
  parameter int JAM = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int W = $clog2(JAM);
  localparam logic [W-1:0] LAST_C = W'(JAM - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST_C);

  // R5
  jam_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hd_tx_coll_ctrl.sv
module hd_tx_coll_ctrl
  import hd_tx_pkg::*;
#(
  parameter int IFG1_NIB = 15,
  parameter int IFG2_NIB = 9,
  parameter int WIN_NIB  = 128,
  parameter int JAM_NIB  = 8,
  parameter int FCS_NIB  = 8,
  parameter int TAIL_NIB = 3,
  parameter int RTRY_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_req_i,
  input  logic              crs_i,
  input  logic              col_i,
  input  logic              pre_done_i,
  input  logic              sfd_sent_i,
  input  logic              fcs_active_i,
  input  logic              last_nib_i,
  input  logic              lc_irq_en_i,
  input  logic              lc_clr_i,
  output logic              tx_start_o,
  output logic              jam_o,
  output logic              retry_o,
  output logic              abort_o,
  output logic              late_col_o,
  output logic              irq_o,
  output logic [RTRY_W-1:0] retry_cnt_o
);
  localparam int FW = $clog2(FCS_NIB + 1);
  localparam logic [FW-1:0] TAIL_C = FW'(FCS_NIB - TAIL_NIB);
  localparam logic [FW-1:0] FMAX_C = FW'(FCS_NIB);
  localparam logic [RTRY_W-1:0] RMAX_C = '1;

  tx_state_e         state_q;
  logic              pre_ok_q, col_pend_q, col_late_q, late_q;
  logic [FW-1:0]     fcs_cnt_q;
  logic [RTRY_W-1:0] rtry_q;
  logic              defer_ready, win_late, jam_last;
  logic              in_tx, tail_ign, col_hit, col_seen, to_jam, frame_done;

  hd_tx_defer #(.IFG1(IFG1_NIB), .IFG2(IFG2_NIB)) i_defer (
    .clk_i, .rst_ni, .clr_i(state_q != ST_IDLE), .crs_i, .ready_o(defer_ready));

  hd_tx_window #(.WIN(WIN_NIB)) i_window (
    .clk_i, .rst_ni, .start_i(tx_start_o), .sfd_i(sfd_sent_i && in_tx), .late_o(win_late));

  hd_tx_jam #(.JAM(JAM_NIB)) i_jam (
    .clk_i, .rst_ni, .run_i(state_q == ST_JAM), .last_o(jam_last));

  assign in_tx      = (state_q == ST_TX);
  assign tx_start_o = (state_q == ST_IDLE) && defer_ready && tx_req_i && !crs_i;
  assign tail_ign   = fcs_active_i && (fcs_cnt_q >= TAIL_C);
  assign col_hit    = in_tx && col_i && !tail_ign;
  assign col_seen   = col_hit || col_pend_q;
  // jam waits for the preamble to finish
  assign to_jam     = in_tx && col_seen && (pre_ok_q || pre_done_i);
  assign frame_done = in_tx && last_nib_i && !col_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pre_ok_q   <= 1'b0;
      col_pend_q <= 1'b0;
      col_late_q <= 1'b0;
      fcs_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (tx_start_o) begin
          state_q    <= ST_TX;
          pre_ok_q   <= 1'b0;
          col_pend_q <= 1'b0;
          col_late_q <= 1'b0;
          fcs_cnt_q  <= '0;
        end
        ST_TX: begin
          if (pre_done_i) pre_ok_q <= 1'b1;
          if (fcs_active_i && fcs_cnt_q != FMAX_C) fcs_cnt_q <= fcs_cnt_q + 1'b1;
          if (col_hit && !col_pend_q) begin
            col_pend_q <= 1'b1;
            col_late_q <= win_late;
          end
          if (to_jam)          state_q <= ST_JAM;
          else if (frame_done) state_q <= ST_IDLE;
        end
        ST_JAM: if (jam_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign jam_o   = (state_q == ST_JAM);
  assign retry_o = jam_last && !col_late_q;
  assign abort_o = jam_last && col_late_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rtry_q <= '0;
    else if (abort_o || frame_done)     rtry_q <= '0;
    else if (retry_o && rtry_q != RMAX_C) rtry_q <= rtry_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       late_q <= 1'b0;
    else if (abort_o)  late_q <= 1'b1;   // set beats clear
    else if (lc_clr_i) late_q <= 1'b0;
  end

  assign late_col_o  = late_q;
  assign irq_o       = late_q && lc_irq_en_i;
  assign retry_cnt_o = rtry_q;

  // R9
  abort_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (late_col_o && retry_cnt_o == '0));
  // R5
  retry_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o && retry_cnt_o != RMAX_C) |=> (retry_cnt_o == $past(retry_cnt_o) + 1'b1));
  // R6
  jam_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_o) |-> $past(pre_ok_q || pre_done_i));
  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_col_o && !lc_clr_i) |=> late_col_o);
  // R8
  tail_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tx && last_nib_i && !col_pend_q) |=> (!jam_o && !tx_start_o || state_q == ST_IDLE));
endmodule

// File: tb/test_hd_tx_coll_ctrl.sv
`timescale 1ns/1ps
module test_hd_tx_coll_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_req_i = 0, crs_i = 0, col_i = 0, pre_done_i = 0, sfd_sent_i = 0;
  logic fcs_active_i = 0, last_nib_i = 0, lc_irq_en_i = 0, lc_clr_i = 0;
  logic tx_start_o, jam_o, retry_o, abort_o, late_col_o, irq_o;
  logic [3:0] retry_cnt_o;

  hd_tx_coll_ctrl i_hd_tx_coll_ctrl (
    .clk_i(clk), .rst_ni, .tx_req_i, .crs_i, .col_i, .pre_done_i, .sfd_sent_i,
    .fcs_active_i, .last_nib_i, .lc_irq_en_i, .lc_clr_i, .tx_start_o, .jam_o,
    .retry_o, .abort_o, .late_col_o, .irq_o, .retry_cnt_o);

  always #2.5 clk = ~clk;

  typedef struct { int kind; int cyc; string req; } ev_t;
  ev_t exp_q[$];
  string kname [4] = '{"START", "JAM", "RETRY", "ABORT"};
  string kreq  [4] = '{"R1", "R8", "R5", "R9"};
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic jam_d = 1'b0;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(int k, int c, string r);
    exp_q.push_back('{k, c, r});
  endtask

  task automatic obs(int k, logic hit);
    ev_t e;
    if (!hit) return;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s: unexpected %s at cycle %0d, expected none", kreq[k], kname[k], cyc);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != k || e.cyc != cyc) begin
      n_fail++;
      $display("FAIL %s: actual %s at cycle %0d, expected %s at cycle %0d",
               e.req, kname[k], cyc, kname[e.kind], e.cyc);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      obs(0, tx_start_o);
      obs(1, jam_o && !jam_d);
      obs(2, retry_o);
      obs(3, abort_o);
      jam_d = jam_o;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic send_hdr(int s, output int sfd_c);
    go_until(s + 1); pre_done_i = 1; tick(); pre_done_i = 0;
    sfd_c = cyc; sfd_sent_i = 1; tick(); sfd_sent_i = 0;
  endtask

  task automatic send_fcs(int col_at);  // col_at < 0: none
    for (int i = 0; i < 8; i++) begin
      fcs_active_i = 1; last_nib_i = (i == 7); col_i = (i == col_at);
      tick();
    end
    fcs_active_i = 0; last_nib_i = 0; col_i = 0;
  endtask

  task automatic pulse_col(int c);
    go_until(c); col_i = 1; tick(); col_i = 0;
  endtask

  initial begin
    int s, sc, f, idle;
    repeat (3) tick();
    chk("R1 reset start", tx_start_o, 0);
    chk("R5 reset jam", jam_o, 0);
    chk("R10 reset flag", late_col_o, 0);
    chk("R12 reset count", retry_cnt_o, 0);
    rst_ni = 1; tx_req_i = 1;

    // A: first deferral, frame with collision in FCS tail
    expect_ev(0, 24, "R2"); go_until(24); s = 24;
    go_until(s + 2); pre_done_i = 1; tick(); pre_done_i = 0;
    sfd_sent_i = 1; tick(); sfd_sent_i = 0;
    go_until(s + 10);
    send_fcs(5);  // R8: ignored
    idle = cyc;
    chk("R8 no jam", jam_o, 0);

    // B: collision before preamble end
    s = idle + 24; expect_ev(0, s, "R2"); go_until(s);
    pulse_col(s + 2);
    go_until(s + 5); expect_ev(1, s + 6, "R6"); expect_ev(2, s + 13, "R6");
    pre_done_i = 1; tick(); pre_done_i = 0;
    go_until(s + 14); idle = cyc;
    chk("R5 count", retry_cnt_o, 1);

    // C: carrier in phase 1 and phase 2, then last in-window collision
    s = idle + 39; expect_ev(0, s, "R3");
    go_until(idle + 14); crs_i = 1; tick(); crs_i = 0;
    go_until(idle + 30); crs_i = 1; tick(); crs_i = 0;
    go_until(s);
    send_hdr(s, sc);
    expect_ev(1, sc + 129, "R4"); expect_ev(2, sc + 136, "R4");
    pulse_col(sc + 128);
    go_until(sc + 137); idle = cyc;
    chk("R5 count", retry_cnt_o, 2);

    // D: carrier in the ready cycle, then first late collision
    s = idle + 49; expect_ev(0, s, "R1");
    go_until(idle + 24); crs_i = 1; tick(); crs_i = 0;
    go_until(s);
    send_hdr(s, sc);
    expect_ev(1, sc + 130, "R4"); expect_ev(3, sc + 137, "R9");
    pulse_col(sc + 129);
    go_until(sc + 138); idle = cyc;
    chk("R9 flag", late_col_o, 1);
    chk("R9 count", retry_cnt_o, 0);
    chk("R11 masked", irq_o, 0);
    lc_irq_en_i = 1; #1;
    chk("R11 enabled", irq_o, 1);

    // E: late FCS collision, clear in the abort cycle
    s = idle + 24; expect_ev(0, s, "R2"); go_until(s);
    send_hdr(s, sc);
    f = sc + 140; go_until(f);
    expect_ev(1, f + 5, "R7"); expect_ev(3, f + 12, "R7");
    for (int i = 0; i < 5; i++) begin
      fcs_active_i = 1; col_i = (i == 4); tick();
    end
    fcs_active_i = 0; col_i = 0;
    go_until(f + 12); lc_clr_i = 1; tick(); lc_clr_i = 0;
    idle = cyc;
    chk("R10 set wins", late_col_o, 1);
    lc_clr_i = 1; tick(); lc_clr_i = 0;
    chk("R10 cleared", late_col_o, 0);
    chk("R11 cleared", irq_o, 0);

    // F: retry then clean frame clears count
    s = idle + 24; expect_ev(0, s, "R2"); go_until(s);
    send_hdr(s, sc);
    expect_ev(1, sc + 6, "R5"); expect_ev(2, sc + 13, "R5");
    pulse_col(sc + 5);
    go_until(sc + 14); idle = cyc;
    chk("R5 count", retry_cnt_o, 1);
    s = idle + 24; expect_ev(0, s, "R12"); go_until(s);
    send_hdr(s, sc);
    go_until(s + 6);
    send_fcs(-1);
    chk("R12 cleared", retry_cnt_o, 0);
    tx_req_i = 0;
    repeat (30) tick();
    chk("R1 pending events", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule